// File: doc/BRIEF.md
# Big-Endian Load/Store Data Memory

This block is the data-side memory of a 32-bit load/store processor. Each cycle it takes a base register value, a signed 16-bit displacement and a 6-bit operation code. It forms the byte address itself, then serves a whole-word or single-byte access against an array of 32-bit words. Byte lanes are numbered from the most significant end of a word.

Reads are combinational from the current array contents. Writes commit on the rising clock edge. Word accesses whose byte address is not a multiple of four are flagged, and any store they carry is dropped. The depth is a power-of-two number of words set by a parameter. Address bits above the word index are not decoded.

Top module: `bemem_unit`

## Requirements
- R1: Reset (`rst_n` low, asynchronous) clears every word to zero, so a word load after reset returns 0.
- R2: The byte address is `base_val` plus `offset` sign-extended to 32 bits. A negative displacement reaches a lower address.
- R3: Opcode 43 (word store) at an address with bits [1:0] = 0 writes all of `st_data` into the addressed word at the next rising edge. Opcode 35 (word load) returns that word on `ld_data` in the same cycle it is presented.
- R4: Byte k of a word, where k is address bits [1:0], occupies word bits [31-8k:24-8k]. Byte 0 is the most significant byte.
- R5: Opcode 32 (byte load) returns the addressed byte in `ld_data[7:0]` and copies its bit 7 into `ld_data[31:8]`.
- R6: Opcode 40 (byte store) writes `st_data[7:0]` into the addressed byte only. The other three bytes of that word keep their values.
- R7: For opcodes 35 and 43, a nonzero address bits [1:0] sets `misalign` high. A word store in that case changes nothing. A word load in that case returns 0.
- R8: Byte opcodes never raise `misalign`. Any opcode other than 32, 35, 40 or 43 writes nothing and returns `ld_data` = 0 with `misalign` low.
- R9: Only address bits [log2(DEPTH)+1:2] select the word. Higher bits are ignored, so addresses wrap modulo 4*DEPTH bytes (256 bytes by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears the array |
| op_code | input | 6 | Operation: 35 word load, 43 word store, 32 byte load, 40 byte store |
| base_val | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| st_data | input | 32 | Store data; byte stores use bits [7:0] |
| ld_data | output | 32 | Load result, combinational |
| misalign | output | 1 | Word access not on a four-byte boundary |

## Verification
A word is first stored, then read back as a whole and as each of its four bytes. This tells apart big-endian lane numbering from little-endian, and sign extension from zero fill.

Byte stores into the middle lanes and the last lane of the array are followed by word loads. These show that only one lane moved. Misaligned word stores followed by a load of the same word show that the write was suppressed.

Negative displacements and bases with bits above the index set separate correct address arithmetic from truncation or wrap errors. An unused opcode with all-ones store data is followed by a reload, which shows that nothing leaked into the array.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [5:0] {
    OP_LB = 6'd32,
    OP_LW = 6'd35,
    OP_SB = 6'd40,
    OP_SW = 6'd43
  } mem_op_e;

  // Byte address from base and sign-extended displacement.
  function automatic logic [31:0] calc_ea(input logic [31:0] base, input logic [15:0] disp);
    return base + {{16{disp[15]}}, disp};
  endfunction

  // Write mask for big-endian byte k: mask bit j covers word bits [8j+7:8j].
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] k);
    return 4'b1000 >> k;
  endfunction

  // Pick big-endian byte k out of a word.
  function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] k);
    logic [7:0] b;
    case (k)
      2'd0:    b = w[31:24];
      2'd1:    b = w[23:16];
      2'd2:    b = w[15:8];
      default: b = w[7:0];
    endcase
    return b;
  endfunction

  function automatic logic [31:0] sext8(input logic [7:0] b);
    return {{24{b[7]}}, b};
  endfunction

endpackage

// File: rtl/dmem_agen.sv
module dmem_agen (
  input  logic [31:0] base_val,
  input  logic [15:0] offset,
  output logic [31:0] eff_addr
);
  import dmem_pkg::*;

  always_comb eff_addr = calc_ea(base_val, offset);

endmodule

// File: rtl/dmem_access_ctl.sv
module dmem_access_ctl (
  input  logic [5:0] op_code,
  input  logic [1:0] addr_lo,
  output logic       is_lw,
  output logic       is_lb,
  output logic [3:0] byte_we,
  output logic       misalign
);
  import dmem_pkg::*;

  logic is_sw, is_sb, word_op, off_grid;

  always_comb begin
    is_lw    = (op_code == OP_LW);
    is_sw    = (op_code == OP_SW);
    is_lb    = (op_code == OP_LB);
    is_sb    = (op_code == OP_SB);
    word_op  = is_lw | is_sw;
    off_grid = (addr_lo != 2'b00);
    misalign = word_op & off_grid;
    byte_we  = '0;
    if (is_sw && !off_grid) byte_we = 4'hF;
    else if (is_sb)         byte_we = lane_mask(addr_lo);
  end

endmodule

// File: rtl/dmem_lane_unit.sv
module dmem_lane_unit (
  input  logic [31:0] rd_word,
  input  logic [31:0] st_data,
  input  logic [1:0]  addr_lo,
  input  logic        is_lw,
  input  logic        is_lb,
  input  logic        misalign,
  input  logic [3:0]  byte_we,
  output logic [31:0] ld_data,
  output logic [31:0] wr_word
);
  import dmem_pkg::*;

  logic full_word;

  always_comb begin
    full_word = (byte_we == 4'hF);
    // A byte store replicates its byte on every lane; the mask picks one.
    wr_word = full_word ? st_data : {4{st_data[7:0]}};
    if (is_lw && !misalign) ld_data = rd_word;
    else if (is_lb)         ld_data = sext8(pick_byte(rd_word, addr_lo));
    else                    ld_data = '0;
  end

endmodule

// File: rtl/dmem_store_array.sv
module dmem_store_array #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [3:0]       byte_we,
  input  logic [31:0]      wr_word,
  output logic [31:0]      rd_word
);

  for (genvar j = 0; j < 4; j++) begin : g_lane
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
      end else if (byte_we[j]) begin
        cells[idx] <= wr_word[8*j +: 8];
      end
    end

    assign rd_word[8*j +: 8] = cells[idx];
  end

endmodule

// File: rtl/bemem_unit.sv
module bemem_unit #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  op_code,
  input  logic [31:0] base_val,
  input  logic [15:0] offset,
  input  logic [31:0] st_data,
  output logic [31:0] ld_data,
  output logic        misalign
);

  logic [31:0]      eff_addr;
  logic [IDX_W-1:0] word_idx;
  logic             is_lw, is_lb;
  logic [3:0]       byte_we;
  logic [31:0]      rd_word, wr_word;
  logic             unused_hi_addr;

  dmem_agen u_agen (
    .base_val (base_val),
    .offset   (offset),
    .eff_addr (eff_addr)
  );

  assign word_idx       = eff_addr[IDX_W+1:2];
  assign unused_hi_addr = ^eff_addr[31:IDX_W+2];

  dmem_access_ctl u_ctl (
    .op_code  (op_code),
    .addr_lo  (eff_addr[1:0]),
    .is_lw    (is_lw),
    .is_lb    (is_lb),
    .byte_we  (byte_we),
    .misalign (misalign)
  );

  dmem_store_array #(.DEPTH(DEPTH)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (word_idx),
    .byte_we (byte_we),
    .wr_word (wr_word),
    .rd_word (rd_word)
  );

  dmem_lane_unit u_lane (
    .rd_word  (rd_word),
    .st_data  (st_data),
    .addr_lo  (eff_addr[1:0]),
    .is_lw    (is_lw),
    .is_lb    (is_lb),
    .misalign (misalign),
    .byte_we  (byte_we),
    .ld_data  (ld_data),
    .wr_word  (wr_word)
  );

endmodule

// File: rtl/dmem_unit_chk.sv
module dmem_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  op_code,
  input logic [1:0]  addr_lo,
  input logic        misalign,
  input logic [3:0]  byte_we,
  input logic [31:0] ld_data
);

  logic op_known;
  assign op_known = (op_code == 6'd32) || (op_code == 6'd35) ||
                    (op_code == 6'd40) || (op_code == 6'd43);

  assert_sw_full_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 6'd43 && addr_lo == 2'b00) |-> (byte_we == 4'hF && !misalign));

  assert_lb_sign_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 6'd32) |-> (ld_data[31:8] == {24{ld_data[7]}}));

  assert_sb_single_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 6'd40) |-> ($countones(byte_we) == 1));

  assert_misalign_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (byte_we == 4'h0));

  assert_lw_misalign_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 6'd35 && addr_lo != 2'b00) |-> (misalign && ld_data == 32'h0));

  assert_byte_ops_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 6'd32 || op_code == 6'd40) |-> !misalign);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_known |-> (byte_we == 4'h0 && ld_data == 32'h0 && !misalign));

endmodule

bind bemem_unit dmem_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_code  (op_code),
  .addr_lo  (eff_addr[1:0]),
  .misalign (misalign),
  .byte_we  (byte_we),
  .ld_data  (ld_data)
);

// File: tb/bemem_unit_test.sv
module bemem_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  typedef struct packed {
    logic [5:0]  op;
    logic [31:0] base;
    logic [15:0] off;
    logic [31:0] sd;
    logic [31:0] ld;
    logic        mis;
    logic [7:0]  req;
  } vec_t;

  // R1..R9 as noted per line
  localparam vec_t VEC [NV] = '{
    '{6'd35, 32'h10,  16'h0000, 32'h0,        32'h0,        1'b0, 8'd1}, // R1 cleared
    '{6'd43, 32'h10,  16'h0004, 32'hA1B2C3D4, 32'h0,        1'b0, 8'd3}, // R3 store 0x14
    '{6'd35, 32'h20,  16'hFFF4, 32'h0,        32'hA1B2C3D4, 1'b0, 8'd2}, // R2 negative disp
    '{6'd32, 32'h14,  16'h0000, 32'h0,        32'hFFFFFFA1, 1'b0, 8'd4}, // R4 byte 0 is MSB
    '{6'd32, 32'h14,  16'h0001, 32'h0,        32'hFFFFFFB2, 1'b0, 8'd4}, // R4
    '{6'd32, 32'h15,  16'h0001, 32'h0,        32'hFFFFFFC3, 1'b0, 8'd5}, // R5
    '{6'd32, 32'h17,  16'h0000, 32'h0,        32'hFFFFFFD4, 1'b0, 8'd5}, // R5
    '{6'd40, 32'h14,  16'h0002, 32'h12345677, 32'h0,        1'b0, 8'd6}, // R6 byte store
    '{6'd35, 32'h14,  16'h0000, 32'h0,        32'hA1B277D4, 1'b0, 8'd6}, // R6 others kept
    '{6'd32, 32'h16,  16'h0000, 32'h0,        32'h00000077, 1'b0, 8'd5}, // R5 positive
    '{6'd43, 32'h14,  16'h0001, 32'hDEADBEEF, 32'h0,        1'b1, 8'd7}, // R7 flagged
    '{6'd35, 32'h14,  16'h0000, 32'h0,        32'hA1B277D4, 1'b0, 8'd7}, // R7 no write
    '{6'd35, 32'h14,  16'h0002, 32'h0,        32'h0,        1'b1, 8'd7}, // R7 load zero
    '{6'd40, 32'h19,  16'h0000, 32'h000000AB, 32'h0,        1'b0, 8'd8}, // R8 byte unaligned ok
    '{6'd35, 32'h18,  16'h0000, 32'h0,        32'h00AB0000, 1'b0, 8'd4}, // R4 lane 1
    '{6'd0,  32'h18,  16'h0000, 32'hFFFFFFFF, 32'h0,        1'b0, 8'd8}, // R8 unknown op
    '{6'd35, 32'h18,  16'h0000, 32'h0,        32'h00AB0000, 1'b0, 8'd8}, // R8 nothing written
    '{6'd43, 32'h118, 16'h0000, 32'h55667788, 32'h0,        1'b0, 8'd9}, // R9 high bits ignored
    '{6'd35, 32'h0,   16'h0018, 32'h0,        32'h55667788, 1'b0, 8'd9}, // R9 wrap
    '{6'd35, 32'h100, 16'hFF18, 32'h0,        32'h55667788, 1'b0, 8'd2}  // R2
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  op_code = 6'd0;
  logic [31:0] base_val = '0;
  logic [15:0] offset = '0;
  logic [31:0] st_data = '0;
  logic [31:0] ld_data;
  logic        misalign;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bemem_unit uut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .base_val(base_val),
    .offset(offset), .st_data(st_data), .ld_data(ld_data), .misalign(misalign)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, sample 2 time units later, commit at the rising edge.
  task automatic access(input logic [5:0] op, input logic [31:0] b, input logic [15:0] o,
                        input logic [31:0] sd);
    @(negedge clk);
    op_code = op; base_val = b; offset = o; st_data = sd;
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      access(VEC[v].op, VEC[v].base, VEC[v].off, VEC[v].sd);
      check($sformatf("R%0d ld v%0d", VEC[v].req, v), ld_data, VEC[v].ld);
      check($sformatf("R%0d mis v%0d", VEC[v].req, v), {31'b0, misalign}, {31'b0, VEC[v].mis});
    end

    // R6 / R5: last byte of the array
    access(6'd40, 32'hFF, 16'h0000, 32'h00000080);
    access(6'd35, 32'hFC, 16'h0000, 32'h0);
    check("R6 last lane", ld_data, 32'h00000080);
    access(6'd32, 32'hFF, 16'h0000, 32'h0);
    check("R5 last byte", ld_data, 32'hFFFFFF80);

    // R7: word load at low pair 3
    access(6'd35, 32'hFF, 16'h0000, 32'h0);
    check("R7 lw off 3", {31'b0, misalign}, 32'h1);

    // R1: reset mid-run clears contents
    @(negedge clk) rst_n = 1'b0; op_code = 6'd0;
    @(negedge clk) rst_n = 1'b1;
    access(6'd35, 32'h18, 16'h0000, 32'h0);
    check("R1 reset clears", ld_data, 32'h0);
    access(6'd35, 32'h14, 16'h0000, 32'h0);
    check("R1 reset clears 0x14", ld_data, 32'h0);

    access(6'd0, 32'h0, 16'h0, 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule